// File: doc/BRIEF.md
# Converter Power-State Controller

This block decides when a serial sampling converter may power its analog sections. It watches the serial-clock falling edges, the frame-sync line, chip select and two configuration bits. From these it selects one of five states: off, recovering, active, automatic power-down and software power-down. It drives enables for the comparator, the serial-clock input buffer and the reference, an output enable for the serial data line, and a ready flag. The frame controller uses the ready flag to mark a frame's result as invalid while the analog front end is still recovering.

Every input is synchronous to the system clock. A falling edge of the serial clock arrives as a one-cycle strobe, `sclk_fall`. The interface mode is fixed each time chip select falls. Frame sync low at that moment selects frame-sync (DSP) mode. Frame sync high selects microcontroller mode, in which every group of `FRAME_LEN` clock edges is one frame.

Configuration writes go into a pending register. The pending values only take effect at the next frame start. This is why a power-down request always lands one frame after it is written. Recovery is counted in serial-clock edges. An automatic power-down recovers in `AUTO_REC` edges, and a software power-down or a new chip select recovers in `SOFT_REC` edges.

Top module: `adc_pwr_ctl`

## Requirements
- R1: While `cs_n` is high, the block enters the off state (`pwr_state` 0) one cycle later. In that state `comp_en`, `clkbuf_en`, `ref_en`, `ready` and `sdo_oe` are all 0, and the pending configuration bits are cleared, so a software power-down written before chip select rose has no effect after it falls again.
- R2: In the cycle where `cs_n` is low and the block is off, `dsp_mode` becomes the inverse of `fsync`, and the block enters recovery (`pwr_state` 4). `ready` stays 0 until `SOFT_REC` (16) further clock edges have arrived.
- R3: DSP mode, auto power-down latched as enabled: a frame starts on a clock edge with `fsync` high. If the 17th edge of a frame has `fsync` low, the block enters automatic power-down (`pwr_state` 2). If that edge has `fsync` high, it starts a new frame and the block stays active.
- R4: Microcontroller mode, auto power-down latched as enabled: once 16 edges have completed a frame and `IDLE_CYC` (8) system cycles pass with no further edge, the block enters automatic power-down. It stays there while no edge arrives.
- R5: When the latched auto power-down enable is 0, the active state is never left because of a missing frame sync or an idle clock.
- R6: Automatic power-down ends when `fsync` is high (DSP mode) or on the next clock edge (microcontroller mode). The block then recovers for exactly `AUTO_REC` (1) edge before `ready` is 1. In DSP mode, edges with `fsync` low do not wake it.
- R7: A write of `cfg_swpd`=1 during a frame leaves the block active for the rest of that frame. The block enters software power-down (`pwr_state` 3) on the next frame-start edge.
- R8: Software power-down ends at the first frame start after a write of `cfg_swpd`=0. That frame is a recovery frame: `ready` stays 0 for 15 edges and becomes 1 after the 16th.
- R9: `comp_en` is 1 only when active or recovering. `ref_en` is 1 when active, recovering or in automatic power-down, and 0 in software power-down. `ready` is 1 only when active.
- R10: In DSP mode, `clkbuf_en` is 0 in both power-down states. In microcontroller mode, `clkbuf_en` stays 1 in every state except off.
- R11: `pwr_state` encodes off=0, active=1, automatic power-down=2, software power-down=3, recovering=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| fsync | input | 1 | Frame sync level |
| sclk_fall | input | 1 | One-cycle strobe per serial-clock falling edge |
| cfg_wr | input | 1 | Strobe that loads the pending configuration |
| cfg_swpd | input | 1 | Software power-down request (1 = power down) |
| cfg_autoen | input | 1 | Auto power-down enable (1 = enabled) |
| dsp_mode | output | 1 | 1 when frame-sync mode was latched at chip select |
| pwr_state | output | 3 | Current power state (encoding in R11) |
| comp_en | output | 1 | Comparator power enable |
| clkbuf_en | output | 1 | Serial-clock input buffer power enable |
| ref_en | output | 1 | Reference power enable |
| ready | output | 1 | Conversions valid; low during recovery |
| sdo_oe | output | 1 | Serial data output enable (0 = tri-stated) |

## Verification
The bench walks both interface modes through every state and counts edges exactly at the boundaries. It tests the 17th DSP edge with and without frame sync, and the eighth versus the seventh idle cycle in microcontroller mode. An off-by-one frame counter would power down one edge early or one edge late. It also sweeps the 16-edge software recovery and the single-edge automatic recovery. A design that counted the waking edge, or forgot it, would raise `ready` one edge early or late.

Further checks target configuration timing. A software power-down must not happen inside the frame in which it was written. A DSP clock edge without frame sync must not wake the block. A pending power-down request must not survive chip select. Each of these would show as a wrong `pwr_state` at the sampled point.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

   typedef enum logic [2:0] {
      PS_OFF    = 3'd0,
      PS_ACTIVE = 3'd1,
      PS_AUTO   = 3'd2,
      PS_SOFT   = 3'd3,
      PS_WAKE   = 3'd4
   } pwr_state_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_pwr_frame.sv
// Frame position tracker: finds frame starts, the missing-sync edge in
// DSP mode and the end of an idle gap in microcontroller mode.
module adc_pwr_frame #(
   parameter int unsigned FRAME_LEN = 16,
   parameter int unsigned IDLE_CYC  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic dsp,
   input  logic fsync,
   input  logic sclk_fall,
   output logic frame_start,
   output logic dsp_gap,
   output logic mcu_idle
);
   localparam int unsigned BW = $clog2(FRAME_LEN + 1);
   localparam int unsigned IW = $clog2(IDLE_CYC + 1);
   localparam logic [BW-1:0] POS_LAST = BW'(FRAME_LEN);
   localparam logic [BW-1:0] POS_WRAP = BW'(FRAME_LEN - 1);
   localparam logic [IW-1:0] IDLE_TOP = IW'(IDLE_CYC - 1);

   logic [BW-1:0] pos;
   logic [IW-1:0] idle_cnt;
   logic          at_rest;

   assign at_rest     = (pos == '0);
   assign frame_start = sclk_fall && (dsp ? fsync : at_rest);
   assign dsp_gap     = sclk_fall && dsp && !fsync && (pos == POS_LAST);
   assign mcu_idle    = !dsp && at_rest && !sclk_fall && (idle_cnt == IDLE_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (cs_n) begin
         pos <= '0;
      end else if (sclk_fall) begin
         if (frame_start)
            pos <= BW'(1);
         else if (dsp) begin
            if (!at_rest && pos != POS_LAST)
               pos <= pos + BW'(1);
         end else if (pos == POS_WRAP)
            pos <= '0;
         else
            pos <= pos + BW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idle_cnt <= '0;
      else if (cs_n || sclk_fall || !at_rest)
         idle_cnt <= '0;
      else if (idle_cnt != IDLE_TOP)
         idle_cnt <= idle_cnt + IW'(1);
   end

endmodule

// File: rtl/adc_pwr_wake.sv
// Recovery edge counter: loaded on entry to recovery, counts serial edges.
module adc_pwr_wake #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          tick,
   output logic          expire
);
   logic [CW-1:0] left;

   assign expire = tick && !load && (left == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left <= '0;
      else if (load)
         left <= load_val;
      else if (tick && left != '0)
         left <= left - CW'(1);
   end

endmodule

// File: rtl/adc_pwr_ctl.sv
module adc_pwr_ctl
   import adc_pwr_pkg::*;
#(
   parameter int unsigned FRAME_LEN       = 16,
   parameter int unsigned IDLE_CYC        = 8,
   parameter int unsigned SOFT_REC        = 16,
   parameter int unsigned AUTO_REC        = 1,
   parameter bit          CLKBUF_DSP_ONLY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       fsync,
   input  logic       sclk_fall,
   input  logic       cfg_wr,
   input  logic       cfg_swpd,
   input  logic       cfg_autoen,
   output logic       dsp_mode,
   output logic [2:0] pwr_state,
   output logic       comp_en,
   output logic       clkbuf_en,
   output logic       ref_en,
   output logic       ready,
   output logic       sdo_oe
);
   localparam int unsigned REC_MAX = max2(SOFT_REC, AUTO_REC);
   localparam int unsigned CW      = $clog2(REC_MAX + 1);

   if (FRAME_LEN < 2) begin : g_bad_frame
      $error("FRAME_LEN must be at least 2");
   end
   if (IDLE_CYC < 1) begin : g_bad_idle
      $error("IDLE_CYC must be at least 1");
   end
   if (SOFT_REC < 1 || AUTO_REC < 1) begin : g_bad_rec
      $error("recovery lengths must be at least 1");
   end

   pwr_state_t    st, st_nx;
   logic          mode_dsp;
   logic          pend_sw, pend_auto, act_auto;
   logic          frame_start, dsp_gap, mcu_idle;
   logic          tmr_load, tmr_expire, tmr_tick;
   logic [CW-1:0] tmr_val;
   logic          wake_evt, pd_state;

   adc_pwr_frame #(.FRAME_LEN(FRAME_LEN), .IDLE_CYC(IDLE_CYC)) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n        (cs_n),
      .dsp         (mode_dsp),
      .fsync       (fsync),
      .sclk_fall   (sclk_fall),
      .frame_start (frame_start),
      .dsp_gap     (dsp_gap),
      .mcu_idle    (mcu_idle)
   );

   assign tmr_tick = sclk_fall && (st == PS_WAKE);

   adc_pwr_wake #(.CW(CW)) u_wake (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .tick     (tmr_tick),
      .expire   (tmr_expire)
   );

   assign wake_evt = mode_dsp ? fsync : sclk_fall;

   always_comb begin
      st_nx    = st;
      tmr_load = 1'b0;
      tmr_val  = CW'(SOFT_REC);
      unique case (st)
         PS_OFF: begin
            st_nx    = PS_WAKE;
            tmr_load = 1'b1;
         end
         PS_ACTIVE: begin
            if (frame_start && pend_sw)
               st_nx = PS_SOFT;
            else if (act_auto && (dsp_gap || mcu_idle))
               st_nx = PS_AUTO;
         end
         PS_AUTO: begin
            if (wake_evt) begin
               if (frame_start && pend_sw)
                  st_nx = PS_SOFT;
               else begin
                  st_nx    = PS_WAKE;
                  tmr_load = 1'b1;
                  tmr_val  = CW'(AUTO_REC);
               end
            end
         end
         PS_SOFT: begin
            if (frame_start && !pend_sw) begin
               st_nx    = PS_WAKE;
               tmr_load = 1'b1;
            end
         end
         PS_WAKE: begin
            if (frame_start && pend_sw)
               st_nx = PS_SOFT;
            else if (tmr_expire)
               st_nx = PS_ACTIVE;
         end
         default: st_nx = PS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= PS_OFF;
         mode_dsp  <= 1'b0;
         pend_sw   <= 1'b0;
         pend_auto <= 1'b0;
         act_auto  <= 1'b0;
      end else if (cs_n) begin
         st        <= PS_OFF;
         pend_sw   <= 1'b0;
         pend_auto <= 1'b0;
         act_auto  <= 1'b0;
      end else begin
         st <= st_nx;
         if (st == PS_OFF)
            mode_dsp <= !fsync;
         if (cfg_wr) begin
            pend_sw   <= cfg_swpd;
            pend_auto <= cfg_autoen;
         end
         if (frame_start)
            act_auto <= pend_auto;
      end
   end

   assign pd_state  = (st == PS_AUTO) || (st == PS_SOFT);
   assign dsp_mode  = mode_dsp;
   assign pwr_state = st;
   assign comp_en   = (st == PS_ACTIVE) || (st == PS_WAKE);
   assign ref_en    = (st == PS_ACTIVE) || (st == PS_WAKE) || (st == PS_AUTO);
   assign ready     = (st == PS_ACTIVE);
   assign sdo_oe    = (st != PS_OFF);

   if (CLKBUF_DSP_ONLY) begin : g_clkbuf_dsp
      assign clkbuf_en = (st != PS_OFF) && !(pd_state && mode_dsp);
   end else begin : g_clkbuf_all
      assign clkbuf_en = (st != PS_OFF) && !pd_state;
   end

endmodule

// File: rtl/adc_pwr_ctl_chk.sv
module adc_pwr_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       fsync,
   input logic       sclk_fall,
   input logic       dsp_mode,
   input logic [2:0] pwr_state,
   input logic       comp_en,
   input logic       clkbuf_en,
   input logic       ref_en,
   input logic       ready,
   input logic       sdo_oe
);
   p_cs_forces_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (pwr_state == 3'd0 && !sdo_oe && !ref_en && !comp_en));

   p_ready_after_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(sclk_fall) && $past(pwr_state) == 3'd4));

   p_soft_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd3 && $past(pwr_state) != 3'd3) |-> $past(sclk_fall));

   p_auto_keeps_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd2) |-> (ref_en && !comp_en && !ready));

   p_mcu_clkbuf_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!dsp_mode && pwr_state != 3'd0) |-> clkbuf_en);

   p_mcu_wake_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!dsp_mode && $past(pwr_state) == 3'd2 && pwr_state != 3'd2 && !$past(cs_n))
         |-> $past(sclk_fall));

   p_dsp_wake_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_mode && $past(pwr_state) == 3'd2 && pwr_state == 3'd4) |-> $past(fsync));

endmodule

bind adc_pwr_ctl adc_pwr_ctl_chk i_adc_pwr_ctl_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .fsync     (fsync),
   .sclk_fall (sclk_fall),
   .dsp_mode  (dsp_mode),
   .pwr_state (pwr_state),
   .comp_en   (comp_en),
   .clkbuf_en (clkbuf_en),
   .ref_en    (ref_en),
   .ready     (ready),
   .sdo_oe    (sdo_oe)
);

// File: tb/test_adc_pwr_ctl.sv
module test_adc_pwr_ctl;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, cs_n = 1'b1, fsync = 1'b1, sclk_fall = 1'b0;
   logic cfg_wr = 1'b0, cfg_swpd = 1'b0, cfg_autoen = 1'b0;
   logic fs_idle = 1'b1;
   logic dsp_mode, comp_en, clkbuf_en, ref_en, ready, sdo_oe;
   logic [2:0] pwr_state;

   int n_vec = 0, n_bad = 0;
   bit finished = 1'b0;

   adc_pwr_ctl i_adc_pwr_ctl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fsync(fsync), .sclk_fall(sclk_fall),
      .cfg_wr(cfg_wr), .cfg_swpd(cfg_swpd), .cfg_autoen(cfg_autoen),
      .dsp_mode(dsp_mode), .pwr_state(pwr_state), .comp_en(comp_en),
      .clkbuf_en(clkbuf_en), .ref_en(ref_en), .ready(ready), .sdo_oe(sdo_oe)
   );

   task automatic check(input string req, input int got, input int exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   // packed view {state, comp, clkbuf, ref, ready, oe}
   task automatic look(input string req, input int st, input int cp, input int cb,
                       input int rf, input int rd, input int oe);
      check(req, {pwr_state, comp_en, clkbuf_en, ref_en, ready, sdo_oe},
            (st << 5) | (cp << 4) | (cb << 3) | (rf << 2) | (rd << 1) | oe);
   endtask

   task automatic edge_fall(input logic fs);
      @(negedge clk);
      fsync = fs;
      sclk_fall = 1'b1;
      @(negedge clk);
      sclk_fall = 1'b0;
      fsync = fs_idle;
   endtask

   task automatic cfg(input logic sw, input logic au);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_swpd = sw; cfg_autoen = au;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      finish_run();
   end

   initial begin
      idle(3);
      look("R1 reset", 0, 0, 0, 0, 0, 0);
      rst_n = 1'b1;
      idle(2);
      look("R1 cs high", 0, 0, 0, 0, 0, 0);

      // ---------------- microcontroller mode ----------------
      fs_idle = 1'b1; fsync = 1'b1;
      @(negedge clk); cs_n = 1'b0;
      @(negedge clk);
      look("R2 mcu recovery entry", 4, 1, 1, 1, 0, 1);
      check("R2 mode mcu", dsp_mode, 0);
      for (int i = 1; i <= 16; i++) begin
         edge_fall(1'b1);
         if (i < 16) check("R2 mcu ready low", ready, 0);
         else look("R2 mcu active after 16", 1, 1, 1, 1, 1, 1);
      end
      idle(20);
      look("R5 mcu auto off idle", 1, 1, 1, 1, 1, 1);

      cfg(1'b0, 1'b1);
      for (int i = 0; i < 16; i++) edge_fall(1'b1);
      idle(7);
      look("R4 mcu idle 7", 1, 1, 1, 1, 1, 1);
      idle(1);
      look("R4 R9 R10 mcu auto pd", 2, 0, 1, 1, 0, 1);
      idle(10);
      look("R4 mcu stays auto", 2, 0, 1, 1, 0, 1);

      edge_fall(1'b1);
      look("R6 mcu wake edge", 4, 1, 1, 1, 0, 1);
      edge_fall(1'b1);
      look("R6 mcu ready after 1", 1, 1, 1, 1, 1, 1);

      cfg(1'b1, 1'b0);
      for (int i = 0; i < 14; i++) edge_fall(1'b1);
      look("R7 mcu same frame active", 1, 1, 1, 1, 1, 1);
      edge_fall(1'b1);
      look("R7 R9 R10 mcu soft pd", 3, 0, 1, 0, 0, 1);

      cfg(1'b0, 1'b0);
      for (int i = 0; i < 15; i++) edge_fall(1'b1);
      look("R8 mcu soft held", 3, 0, 1, 0, 0, 1);
      edge_fall(1'b1);
      look("R8 mcu soft exit", 4, 1, 1, 1, 0, 1);
      for (int i = 1; i <= 16; i++) begin
         edge_fall(1'b1);
         if (i < 16) check("R8 mcu recovery ready low", ready, 0);
         else look("R8 mcu active after 16", 1, 1, 1, 1, 1, 1);
      end

      // pending request that must not survive chip select
      cfg(1'b1, 1'b1);
      @(negedge clk); cs_n = 1'b1;
      @(negedge clk);
      look("R1 cs off", 0, 0, 0, 0, 0, 0);

      // ---------------- DSP mode ----------------
      fs_idle = 1'b0;
      @(negedge clk); fsync = 1'b0; cs_n = 1'b0;
      @(negedge clk);
      look("R2 dsp recovery entry", 4, 1, 1, 1, 0, 1);
      check("R2 mode dsp", dsp_mode, 1);
      for (int i = 1; i <= 16; i++) begin
         edge_fall(1'b0);
         if (i < 16) check("R2 dsp ready low", ready, 0);
         else look("R2 dsp active after 16", 1, 1, 1, 1, 1, 1);
      end
      edge_fall(1'b1);
      look("R1 pending cleared by cs", 1, 1, 1, 1, 1, 1);

      cfg(1'b0, 1'b1);
      for (int i = 0; i < 15; i++) edge_fall(1'b0);
      edge_fall(1'b1);
      look("R3 sync on 17th keeps active", 1, 1, 1, 1, 1, 1);
      for (int i = 0; i < 15; i++) edge_fall(1'b0);
      look("R3 16 edges active", 1, 1, 1, 1, 1, 1);
      edge_fall(1'b0);
      look("R3 R9 R10 dsp auto pd", 2, 0, 0, 1, 0, 1);
      for (int i = 0; i < 4; i++) edge_fall(1'b0);
      look("R6 dsp edge no sync stays", 2, 0, 0, 1, 0, 1);
      @(negedge clk); fsync = 1'b1;
      @(negedge clk);
      look("R6 dsp sync wakes", 4, 1, 1, 1, 0, 1);
      edge_fall(1'b1);
      look("R6 dsp ready after 1", 1, 1, 1, 1, 1, 1);

      cfg(1'b1, 1'b0);
      for (int i = 0; i < 15; i++) edge_fall(1'b0);
      look("R7 dsp same frame active", 1, 1, 1, 1, 1, 1);
      edge_fall(1'b1);
      look("R7 R9 R10 dsp soft pd", 3, 0, 0, 0, 0, 1);

      cfg(1'b0, 1'b0);
      for (int i = 0; i < 20; i++) edge_fall(1'b0);
      look("R8 dsp soft held", 3, 0, 0, 0, 0, 1);
      edge_fall(1'b1);
      look("R8 dsp soft exit", 4, 1, 1, 1, 0, 1);
      for (int i = 1; i <= 16; i++) begin
         edge_fall(1'b0);
         if (i < 16) check("R8 dsp recovery ready low", ready, 0);
         else look("R8 dsp active after 16", 1, 1, 1, 1, 1, 1);
      end
      edge_fall(1'b0);
      look("R5 dsp auto off no sync", 1, 1, 1, 1, 1, 1);
      check("R11 active code", pwr_state, 1);

      idle(2);
      finish_run();
   end
endmodule